// File: doc/BRIEF.md
# Streaming Pipelined Integer Square Root

This block takes a stream of unsigned samples and returns, for each one, the integer square root (the largest whole number whose square does not exceed the sample). The root is produced one result bit per stage. Each stage tests a trial value against a running remainder, and the trial bit position moves down two places per stage. A sample `DATA_W` bits wide therefore needs `DATA_W/2` stages and yields a root `DATA_W/2` bits wide.

A build parameter sets where registers sit in the stage chain. In the combinational build there are no registers: the root and the output strobe depend directly on the input. In the last-stage-registered build, one register sits after the final stage. In the fully pipelined build, every stage ends in a register. A sample is accepted only in a cycle where both the data strobe and the cycle signal are high, and the samples of one burst are presented back to back. A small counter-based controller delays the output strobe by the pipeline depth. After the burst stops, it keeps the strobe running until the samples still in flight have left. It then raises a one-cycle burst-end flag.

Consecutive bursts must be separated by at least as many idle cycles as the pipeline latency. The stages themselves run every cycle; only the strobe says which outputs are meaningful.

Top module: `isqrt_stream`

## Requirements
- R1: For every accepted sample x, the output word carried with its strobe equals floor(sqrt(x)), for any even `DATA_W`.
- R2: With `MODE` = `MODE_COMB` (value 0), the root and the output strobe follow the input in the same cycle, with no register on the path.
- R3: With `MODE` = `MODE_LASTREG` (value 1), the result of a sample presented in cycle n appears with its strobe in cycle n+1.
- R4: With `MODE` = `MODE_PIPE` (value 2), the result of a sample presented in cycle n appears with its strobe in cycle n+`DATA_W`/2.
- R5: A burst of L accepted samples produces exactly L consecutive strobe cycles with results in input order. The strobe continues after the input stops until the last result is out, including for L = 1 and for L shorter than the pipeline depth.
- R6: A cycle with only the data strobe high, or only the cycle signal high, is not accepted and produces no output strobe.
- R7: `out_done` is high for exactly one cycle, the cycle right after the last strobe cycle of a burst, and is low at all other times.
- R8: While reset is low and in the first cycle after it, `out_stb` and `out_done` are 0. In the registered builds, `out_data` is also 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_stb | input | 1 | Input data strobe |
| in_cyc | input | 1 | Input cycle (burst) signal; a sample is taken only when it and `in_stb` are both high |
| in_data | input | DATA_W | Unsigned sample |
| out_data | output | DATA_W/2 | Integer square root, meaningful while `out_stb` is high |
| out_stb | output | 1 | Output strobe, one cycle per result |
| out_done | output | 1 | One-cycle burst-end flag after the last result |

## Verification
The bench builds the block four times and drives all four from the same strobe and cycle signals. Three builds use `DATA_W` = 8, one in each of the three modes, so every 8-bit value can be checked under zero, one and four cycles of latency. The fourth build uses `DATA_W` = 16 in the fully pipelined mode. That build gives an eight-stage drain and exercises the near-overflow roots, such as those of 65535 and 65025. Bursts of one to five samples, which are shorter than the deeper pipelines, run alongside random-length bursts. Idle gaps mix strobe-only and cycle-only cycles.

// File: rtl/isqrt_pkg.sv
// Package: shared mode encoding and latency helper for the streaming
// integer square root. Assumes stage count equals half the sample width.
package isqrt_pkg;

    // Placement of pipeline registers in the stage chain.
    typedef enum logic [1:0] {
        MODE_COMB    = 2'd0,
        MODE_LASTREG = 2'd1,
        MODE_PIPE    = 2'd2
    } isqrt_mode_e;

    // Cycles from sample presentation to result presentation.
    function automatic int stream_latency(isqrt_mode_e mode, int stages);
        case (mode)
            MODE_COMB:    return 0;
            MODE_LASTREG: return 1;
            default:      return stages;
        endcase
    endfunction

endpackage

// File: rtl/isqrt_step.sv
// Module: one digit step of the remainder square root.
// Tests root+mask against the remainder; on success subtracts it and
// sets the result bit, then halves the root. The mask is a constant
// for the stage (1 << MASK_POS), so it is not carried down the chain.
// Assumes W >= 4 and MASK_POS <= W-2.
module isqrt_step #(
    parameter int W        = 8,
    parameter int MASK_POS = 6
) (
    input  logic [W:0]   root_i,
    input  logic [W-1:0] rem_i,
    output logic [W:0]   root_o,
    output logic [W-1:0] rem_o
);
    localparam logic [W:0] MASK  = (W+1)'(1) << MASK_POS;
    localparam logic [W:0] MASK2 = (W+1)'(1) << (MASK_POS + 1);

    logic [W:0] trial;
    logic       take;

    // Trial subtraction and conditional update of root and remainder.
    always_comb begin
        trial = root_i + MASK;
        take  = (trial <= {1'b0, rem_i});
        if (take) begin
            rem_o  = rem_i - trial[W-1:0];
            root_o = (root_i + MASK2) >> 1;
        end else begin
            rem_o  = rem_i;
            root_o = root_i >> 1;
        end
    end
endmodule

// File: rtl/isqrt_root_pipe.sv
// Module: unrolled chain of DATA_W/2 square root steps.
// MODE picks where registers sit: none, after the final stage only, or
// after every stage. Registers advance every cycle; validity is tracked
// outside. Assumes DATA_W is even and at least 4.
module isqrt_root_pipe
    import isqrt_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter isqrt_mode_e MODE   = MODE_PIPE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W/2-1:0] root_o
);
    localparam int N      = DATA_W / 2;
    localparam int ROOT_W = DATA_W / 2;

    // Element k holds the state entering stage k; element N is the result.
    logic [DATA_W:0]   root_s [N+1];
    logic [DATA_W-1:0] rem_s  [N+1];

    assign root_s[0] = '0;
    assign rem_s[0]  = din;

    for (genvar gi = 0; gi < N; gi++) begin : g_stage
        localparam bit REG_HERE = (MODE == MODE_PIPE) ||
                                  ((MODE == MODE_LASTREG) && (gi == N - 1));
        logic [DATA_W:0]   root_c;
        logic [DATA_W-1:0] rem_c;

        isqrt_step #(
            .W        (DATA_W),
            .MASK_POS (DATA_W - 2 - 2*gi)
        ) u_step (
            .root_i (root_s[gi]),
            .rem_i  (rem_s[gi]),
            .root_o (root_c),
            .rem_o  (rem_c)
        );

        if (REG_HERE) begin : g_reg
            logic [DATA_W:0]   root_q;
            logic [DATA_W-1:0] rem_q;
            // Stage register: captures this step's result each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    root_q <= '0;
                    rem_q  <= '0;
                end else begin
                    root_q <= root_c;
                    rem_q  <= rem_c;
                end
            end
            assign root_s[gi+1] = root_q;
            assign rem_s[gi+1]  = rem_q;
        end else begin : g_wire
            assign root_s[gi+1] = root_c;
            assign rem_s[gi+1]  = rem_c;
        end
    end

    assign root_o = root_s[N][ROOT_W-1:0];

    // Final remainder x - r*r never exceeds 2*r for a correct root.
    assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ({2'b00, rem_s[N]} <= ({1'b0, root_s[N]} << 1)));

    // The final root must fit in half the sample width.
    assert_root_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((root_s[N] >> ROOT_W) == '0));
endmodule

// File: rtl/isqrt_flow_ctrl.sv
// Module: stream control for the square root chain.
// With LAT = 0 the strobe passes straight through. Otherwise a head
// counter waits LAT-1 edges from the burst start before raising the
// strobe, and a tail counter keeps the strobe up for LAT-1 edges after
// the input stops so that in-flight results drain. Assumes each burst
// is contiguous and bursts are at least LAT idle cycles apart.
module isqrt_flow_ctrl #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic out_stb,
    output logic out_done
);
    if (LAT == 0) begin : g_pass
        logic prev_act;

        // Remember last cycle's acceptance to spot the end of a burst.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_act <= 1'b0;
            else        prev_act <= act;
        end

        assign out_stb  = act;
        assign out_done = prev_act & ~act;
    end else begin : g_count
        localparam int              CW   = (LAT > 1) ? $clog2(LAT) : 1;
        localparam logic [CW-1:0]   LAST = CW'(LAT - 1);

        logic          busy, closed, stb_q, done_q;
        logic [CW-1:0] head, tail;
        logic [CW-1:0] h_now, t_now;
        logic          live, step_in;

        // Effective counter values, zero outside their phase.
        always_comb begin
            h_now   = busy   ? head : '0;
            t_now   = closed ? tail : '0;
            live    = busy | act;
            step_in = act & ~closed;
        end

        // Fill, run and drain sequencing of the output strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy   <= 1'b0;
                closed <= 1'b0;
                head   <= '0;
                tail   <= '0;
                stb_q  <= 1'b0;
                done_q <= 1'b0;
            end else begin
                done_q <= 1'b0;
                if (live) begin
                    busy <= 1'b1;
                    if (h_now == LAST) stb_q <= 1'b1;
                    else               head  <= h_now + 1'b1;
                    if (!step_in) begin
                        closed <= 1'b1;
                        if (t_now == LAST) begin
                            stb_q  <= 1'b0;
                            done_q <= 1'b1;
                            busy   <= 1'b0;
                            closed <= 1'b0;
                            head   <= '0;
                            tail   <= '0;
                        end else begin
                            tail <= t_now + 1'b1;
                        end
                    end
                end
            end
        end

        assign out_stb  = stb_q;
        assign out_done = done_q;

        // No strobe may be issued outside a burst.
        assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy |-> !stb_q));

        // Strobe is low on the first edge after reset is released.
        assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(rst_n) |-> (!stb_q && !done_q)));
    end
endmodule

// File: rtl/isqrt_stream.sv
// Module: top of the streaming integer square root.
// Combines the unrolled root chain with the strobe controller. The
// controller latency is derived from MODE so strobe and data line up.
// Assumes DATA_W even, at least 4, and bursts spaced by the latency.
module isqrt_stream
    import isqrt_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter isqrt_mode_e MODE   = MODE_PIPE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_stb,
    input  logic                in_cyc,
    input  logic [DATA_W-1:0]   in_data,
    output logic [DATA_W/2-1:0] out_data,
    output logic                out_stb,
    output logic                out_done
);
    localparam int STAGES = DATA_W / 2;
    localparam int LAT    = stream_latency(MODE, STAGES);

    logic accept;

    // A sample counts only when both strobe and cycle are high.
    assign accept = in_stb & in_cyc;

    isqrt_root_pipe #(
        .DATA_W (DATA_W),
        .MODE   (MODE)
    ) u_root (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (in_data),
        .root_o (out_data)
    );

    isqrt_flow_ctrl #(
        .LAT (LAT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (accept),
        .out_stb  (out_stb),
        .out_done (out_done)
    );

    // Burst end flag only right after a strobe cycle, never with one.
    assert_done_after_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done |-> (!out_stb && $past(out_stb))));

    // Two burst-end flags never come back to back.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done |=> !out_done));
endmodule

// File: tb/isqrt_stream_tb.sv
`timescale 1ns/1ps
// Bench: four builds of the square root stream share one input stream.
// Expected strobe, flag and root come from a history of the inputs and
// a reference root computed by counting.
module isqrt_stream_tb;
    import isqrt_pkg::*;

    localparam int HS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_stb = 1'b0;
    logic        in_cyc = 1'b0;
    logic [7:0]  d8 = '0;
    logic [15:0] d16 = '0;

    logic [3:0] o_pipe, o_comb, o_lreg;
    logic [7:0] o_w16;
    logic s_pipe, s_comb, s_lreg, s_w16;
    logic f_pipe, f_comb, f_lreg, f_w16;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit done_flag = 1'b0;

    bit        h_act [HS];
    bit [7:0]  h_d8  [HS];
    bit [15:0] h_d16 [HS];

    always #4 clk = ~clk;

    isqrt_stream #(.DATA_W(8), .MODE(MODE_PIPE)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_cyc(in_cyc), .in_data(d8),
        .out_data(o_pipe), .out_stb(s_pipe), .out_done(f_pipe));
    isqrt_stream #(.DATA_W(8), .MODE(MODE_COMB)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_cyc(in_cyc), .in_data(d8),
        .out_data(o_comb), .out_stb(s_comb), .out_done(f_comb));
    isqrt_stream #(.DATA_W(8), .MODE(MODE_LASTREG)) u_dut_lreg (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_cyc(in_cyc), .in_data(d8),
        .out_data(o_lreg), .out_stb(s_lreg), .out_done(f_lreg));
    isqrt_stream #(.DATA_W(16), .MODE(MODE_PIPE)) u_dut_w16 (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_cyc(in_cyc), .in_data(d16),
        .out_data(o_w16), .out_stb(s_w16), .out_done(f_w16));

    function automatic int unsigned ref_sqrt(int unsigned x);
        int unsigned r = 0;
        while ((r + 1) * (r + 1) <= x) r++;
        return r;
    endfunction

    function automatic bit act_at(int k);
        return (k < 0) ? 1'b0 : h_act[k % HS];
    endfunction

    function automatic int unsigned val_at(int k, bit wide);
        if (k < 0) return 0;
        return wide ? int'(h_d16[k % HS]) : int'(h_d8[k % HS]);
    endfunction

    task automatic expect_eq(string req, string what, int unsigned act_v, int unsigned exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, n, act_v, exp_v);
        end
    endtask

    // Compare one build against the input history shifted by its latency.
    task automatic check_build(string lat_req, string nm, int lat, bit wide,
                               logic stb, logic fl, logic [7:0] data);
        bit exp_stb, exp_done;
        exp_stb  = act_at(n - lat);
        exp_done = act_at(n - lat - 1) & ~exp_stb;
        expect_eq({lat_req, "/R5/R6"}, {nm, " strobe"}, stb, exp_stb);
        expect_eq("R7", {nm, " done"}, fl, exp_done);
        if (exp_stb)
            expect_eq("R1", {nm, " root"}, data, ref_sqrt(val_at(n - lat, wide)));
    endtask

    // Monitor at the falling edge: record inputs, then check outputs.
    always @(negedge clk) begin
        h_act[n % HS] = in_stb & in_cyc;
        h_d8[n % HS]  = d8;
        h_d16[n % HS] = d16;
        if (rst_n) begin
            check_build("R4", "pipe8",  4, 1'b0, s_pipe, f_pipe, {4'b0, o_pipe});
            check_build("R2", "comb8",  0, 1'b0, s_comb, f_comb, {4'b0, o_comb});
            check_build("R3", "lreg8",  1, 1'b0, s_lreg, f_lreg, {4'b0, o_lreg});
            check_build("R4", "pipe16", 8, 1'b1, s_w16,  f_w16,  o_w16);
        end
        n++;
    end

    function automatic logic [15:0] corner16(int i);
        case (i)
            0: return 16'd0;      1: return 16'd65535;  2: return 16'd65025;
            3: return 16'd65024;  4: return 16'd1;      5: return 16'd3;
            6: return 16'd4;      7: return 16'd16383;  8: return 16'd16384;
            default: return 16'd255;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Idle cycles that mix strobe-only and cycle-only patterns (R6).
    task automatic idle(int len);
        for (int i = 0; i < len; i++) begin
            case ($urandom % 3)
                0: begin in_stb = 1'b1; in_cyc = 1'b0; end
                1: begin in_stb = 1'b0; in_cyc = 1'b1; end
                default: begin in_stb = 1'b0; in_cyc = 1'b0; end
            endcase
            d8  = 8'($urandom);
            d16 = 16'($urandom);
            step();
        end
        in_stb = 1'b0;
        in_cyc = 1'b0;
    endtask

    task automatic burst_rand(int len);
        for (int i = 0; i < len; i++) begin
            in_stb = 1'b1; in_cyc = 1'b1;
            d8  = 8'($urandom);
            d16 = 16'($urandom);
            step();
        end
        in_stb = 1'b0; in_cyc = 1'b0;
    endtask

    task automatic burst_corner(int len, int base);
        for (int i = 0; i < len; i++) begin
            in_stb = 1'b1; in_cyc = 1'b1;
            d8  = (((base + i) % 2) == 0) ? 8'(base + i) : 8'(255 - base - i);
            d16 = corner16(base + i);
            step();
        end
        in_stb = 1'b0; in_cyc = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        #2;
        // R8: outputs quiet and registered roots cleared under reset.
        expect_eq("R8", "pipe8 stb in reset", s_pipe, 0);
        expect_eq("R8", "lreg8 stb in reset", s_lreg, 0);
        expect_eq("R8", "pipe16 stb in reset", s_w16, 0);
        expect_eq("R8", "comb8 stb in reset", s_comb, 0);
        expect_eq("R8", "done flags in reset", {f_pipe, f_comb, f_lreg, f_w16}, 0);
        expect_eq("R8", "pipe8 data in reset", o_pipe, 0);
        expect_eq("R8", "lreg8 data in reset", o_lreg, 0);
        expect_eq("R8", "pipe16 data in reset", o_w16, 0);
        rst_n = 1'b1;
        step();
        idle(6);
        // R1 full sweep of the 8-bit range, one long burst.
        for (int v = 0; v < 256; v++) begin
            in_stb = 1'b1; in_cyc = 1'b1;
            d8 = 8'(v);
            d16 = (v < 10) ? corner16(v) : 16'($urandom);
            step();
        end
        in_stb = 1'b0; in_cyc = 1'b0;
        idle(12);
        // R5: bursts shorter than or equal to the pipeline depths.
        for (int l = 1; l <= 5; l++) begin
            burst_corner(l, l);
            idle(11);
        end
        burst_corner(1, 0);
        idle(11);
        for (int b = 0; b < 30; b++) begin
            burst_rand(int'($urandom_range(1, 24)));
            idle(int'($urandom_range(10, 16)));
        end
        idle(20);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule